// File: doc/BRIEF.md
# SD Card Data FIFO with Byte Packing

This block sits between a 32-bit register port and the byte-wide data stream of an SD card. It does not drive the DAT lines or compute CRC16; it only moves payload. A 16-word circular FIFO decouples software, which moves whole words through one data offset, from the card side, which moves one byte per handshake.

In card-to-host mode, bytes arriving from the card are gathered into 32-bit words, lowest byte lane first, and pushed into the FIFO. A word is also pushed early, with zero upper lanes, when the transfer runs out of bytes. In host-to-card mode, words are taken from the FIFO and sent to the card one byte at a time, lowest lane first. Both directions count down a transfer length. Writing the block-count register loads this length as block size times block count. The block raises a data flag and optional data and block interrupts. A debug register shows the live FIFO fill level and a small state code that changes to "data mode" when the transfer length is used up.

Top module: `sd_fifo_packer`

## Requirements
- R1: The FIFO holds 16 words and delivers them in arrival order. A push through the data offset 0x40 while 16 words are held is dropped, and the held words are unchanged.
- R2: A read of the data offset 0x40 while the FIFO is empty returns 0 and leaves the fill level at 0.
- R3: A write to offset 0x50 (block count) loads the remaining byte count with that value times the block size held at offset 0x3C. Every byte moved on the card side lowers the count by one.
- R4: In card-to-host mode, the first card byte of a word fills bits 7:0, the next fills 15:8, then 23:16, then 31:24. The word is pushed after its fourth byte.
- R5: When the remaining count reaches zero part way through a word, that word is pushed with its unfilled upper bytes zero.
- R6: card_rx_ready is low while the FIFO is full, while the remaining count is zero, or when card-to-host mode is off. It returns high once a word is read out of a full FIFO.
- R7: In host-to-card mode, each word taken from the FIFO is sent least significant byte first, one byte per card_tx_valid/card_tx_ready handshake. card_tx_valid stays low once the remaining count is zero.
- R8: Each word the card side pushes into or takes from the FIFO sets status bit 0 (offset 0x20). It also sets status bit 8 when config bit 4 (offset 0x38) is set.
- R9: In host-to-card mode, status bit 9 is set when block size is nonzero, config bit 8 is set, and a sent byte leaves a remaining count that is a multiple of the block size.
- R10: When the remaining count drops to zero, debug register bits 3:0 (offset 0x34) read 1.
- R11: The debug register resets to 0x0000C60F. Bits 8:4 always read the current FIFO fill level. A software write whose bits 3:0 are 0xF stores 0 in those bits.
- R12: Writing 1 to status bits 0, 8 or 9 clears them. irq is high exactly when status bit 8 or bit 9 is set.
- R13: Offset 0x00 selects the direction: bit 0 is card-to-host and bit 1 is host-to-card, with bit 0 winning if both are set. With neither set, no card byte moves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe, one cycle per access |
| reg_rd | input | 1 | Register read strobe; a read of the data offset pops a word |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid in the cycle of reg_rd |
| card_rx_valid | input | 1 | Card offers a byte |
| card_rx_data | input | 8 | Byte from card |
| card_rx_ready | output | 1 | Block accepts the offered byte |
| card_tx_valid | output | 1 | Block offers a byte to the card |
| card_tx_data | output | 8 | Byte to card |
| card_tx_ready | input | 1 | Card accepts the offered byte |
| irq | output | 1 | Interrupt: data or block interrupt pending |

## Verification
The assertions assume that software does not push through the data offset in the same cycle as the card-to-host packer pushes a word, and does not reload the block count while a byte handshake completes. The directed bench keeps to this. It loads lengths only while the card handshakes are idle, and in card-to-host tests it only pops through the data offset. The assertions also assume that block size is not changed in the middle of a host-to-card transfer. The bench sets block size before loading the count and leaves it alone until the transfer ends.

// File: rtl/sdp_pkg.sv
package sdp_pkg;

  // register offsets
  localparam logic [7:0] OFS_MODE = 8'h00;
  localparam logic [7:0] OFS_STAT = 8'h20;
  localparam logic [7:0] OFS_DBG  = 8'h34;
  localparam logic [7:0] OFS_CFG  = 8'h38;
  localparam logic [7:0] OFS_BSZ  = 8'h3C;
  localparam logic [7:0] OFS_DATA = 8'h40;
  localparam logic [7:0] OFS_BCNT = 8'h50;

  // status and config bit positions
  localparam int ST_DATA     = 0;
  localparam int ST_DIRQ     = 8;
  localparam int ST_BIRQ     = 9;
  localparam int CF_DIRQ_EN  = 4;
  localparam int CF_BIRQ_EN  = 8;

  localparam logic [31:0] DBG_RESET   = 32'h0000_C60F;
  localparam logic [3:0]  STATE_DATA  = 4'h1;
  localparam logic [3:0]  STATE_PWRDN = 4'hF;

  // place a byte into a given lane of a partial word
  function automatic logic [31:0] lane_merge(input logic [31:0] acc,
                                             input logic [7:0]  b,
                                             input logic [1:0]  lane);
    return acc | (32'(b) << {lane, 3'b000});
  endfunction

  // software write to the debug register: a power-down code is not kept
  function automatic logic [31:0] dbg_sanitize(input logic [31:0] w);
    logic [31:0] r;
    r = w;
    if (w[3:0] == STATE_PWRDN) r[3:0] = 4'h0;
    return r;
  endfunction

  // debug read view: live fill level replaces bits 8:4
  function automatic logic [31:0] dbg_view(input logic [31:0] q,
                                           input logic [4:0]  lvl);
    return {q[31:9], lvl, q[3:0]};
  endfunction

  // status read view from three stored bits {block, data irq, data flag}
  function automatic logic [31:0] stat_view(input logic [2:0] s);
    logic [31:0] r;
    r = '0;
    r[ST_DATA] = s[0];
    r[ST_DIRQ] = s[1];
    r[ST_BIRQ] = s[2];
    return r;
  endfunction

endpackage

// File: rtl/sdp_word_fifo.sv
module sdp_word_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 32,
  localparam int AW   = $clog2(DEPTH),
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  push_data,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic          full,
  output logic          empty,
  output logic [LW-1:0] level
);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          push_ok, pop_ok;

  function automatic logic [AW-1:0] ptr_step(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (level == LW'(DEPTH));
  assign empty   = (level == '0);
  assign push_ok = push & ~full;
  assign pop_ok  = pop & ~empty;
  assign head    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (push_ok) wr_ptr <= ptr_step(wr_ptr);
      if (pop_ok)  rd_ptr <= ptr_step(rd_ptr);
      case ({push_ok, pop_ok})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  // R1: fill level never exceeds the depth
  a_r1_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LW'(DEPTH));

  // R1: a push into a full FIFO without a pop leaves the level alone
  a_r1_full_push_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop) |=> (level == LW'(DEPTH)));

  // R2: a pop on an empty FIFO does not change the level
  a_r2_empty_pop_held: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && pop && !push) |=> (level == '0));

endmodule

// File: rtl/sdp_rx_packer.sv
module sdp_rx_packer
  import sdp_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        restart,
  input  logic        enable,
  input  logic        last_byte,
  input  logic        fifo_full,
  input  logic        rx_valid,
  input  logic [7:0]  rx_data,
  output logic        rx_ready,
  output logic        byte_take,
  output logic        word_push,
  output logic [31:0] word_out
);

  logic [31:0] acc;
  logic [1:0]  lane;

  always_comb begin
    rx_ready  = enable & ~fifo_full;
    byte_take = rx_valid & rx_ready;
    word_out  = lane_merge(acc, rx_data, lane);
    word_push = byte_take & ((lane == 2'd3) | last_byte);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc  <= '0;
      lane <= '0;
    end else if (restart) begin
      acc  <= '0;
      lane <= '0;
    end else if (byte_take) begin
      if (word_push) begin
        acc  <= '0;
        lane <= '0;
      end else begin
        acc  <= word_out;
        lane <= lane + 1'b1;
      end
    end
  end

  // R5: a word pushed before its fourth lane only at the end of the count
  a_r5_partial_only_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    (word_push && lane != 2'd3) |-> last_byte);

  // R4: lanes below the current one keep their earlier bytes while idle
  a_r4_acc_held: assert property (@(posedge clk) disable iff (!rst_n)
    (!byte_take && !restart) |=> $stable(acc));

endmodule

// File: rtl/sdp_tx_unpacker.sv
module sdp_tx_unpacker (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        restart,
  input  logic        enable,
  input  logic        fifo_empty,
  input  logic [31:0] fifo_head,
  input  logic        bus_pop,
  input  logic        tx_ready,
  output logic        tx_valid,
  output logic [7:0]  tx_data,
  output logic        word_pop,
  output logic        byte_sent
);

  logic [31:0] shreg;
  logic [2:0]  left;

  always_comb begin
    word_pop  = enable & (left == '0) & ~fifo_empty & ~bus_pop;
    tx_valid  = enable & (left != '0);
    tx_data   = shreg[7:0];
    byte_sent = tx_valid & tx_ready;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '0;
      left  <= '0;
    end else if (restart) begin
      shreg <= '0;
      left  <= '0;
    end else if (word_pop) begin
      shreg <= fifo_head;
      left  <= 3'd4;
    end else if (byte_sent) begin
      shreg <= {8'h00, shreg[31:8]};
      left  <= left - 1'b1;
    end
  end

  // R7: an offered byte is held until the card takes it
  a_r7_hold_offer: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !restart && enable) |=> $stable(tx_data));

  // R7: no new word is taken while bytes of the last one are pending
  a_r7_drain_first: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> !word_pop);

endmodule

// File: rtl/sd_fifo_packer.sv
module sd_fifo_packer
  import sdp_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int BSZ_W      = 12,
  parameter int BCNT_W     = 10,
  parameter int ADDR_W     = 8,
  localparam int CNT_W     = BSZ_W + BCNT_W,
  localparam int LW        = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              card_rx_valid,
  input  logic [7:0]        card_rx_data,
  output logic              card_rx_ready,
  output logic              card_tx_valid,
  output logic [7:0]        card_tx_data,
  input  logic              card_tx_ready,
  output logic              irq
);

  // register state
  logic [1:0]        mode_q;
  logic [31:0]       cfg_q;
  logic [BSZ_W-1:0]  bsz_q;
  logic [BCNT_W-1:0] bcnt_q;
  logic [31:0]       dbg_q;
  logic [2:0]        stat_q;     // {block irq, data irq, data flag}
  logic [CNT_W-1:0]  remain_q;
  logic [BSZ_W-1:0]  blk_left_q;

  // decoded accesses
  logic wr_mode_sel, wr_stat, wr_dbg, wr_cfg, wr_bsz, wr_data, wr_bcnt;
  logic rd_data;
  logic rx_mode, tx_mode;

  // internal events, named for the assertions
  logic count_load, rx_take, tx_sent, byte_evt, done_evt;
  logic rx_push, tx_pop, word_evt, blk_evt;

  // FIFO interface
  logic        fifo_push, fifo_pop, fifo_full, fifo_empty;
  logic [31:0] fifo_wdata, fifo_head, rx_word;
  logic [LW-1:0] fifo_level;

  always_comb begin
    wr_mode_sel = reg_wr && (reg_addr == ADDR_W'(OFS_MODE));
    wr_stat     = reg_wr && (reg_addr == ADDR_W'(OFS_STAT));
    wr_dbg      = reg_wr && (reg_addr == ADDR_W'(OFS_DBG));
    wr_cfg      = reg_wr && (reg_addr == ADDR_W'(OFS_CFG));
    wr_bsz      = reg_wr && (reg_addr == ADDR_W'(OFS_BSZ));
    wr_data     = reg_wr && (reg_addr == ADDR_W'(OFS_DATA));
    wr_bcnt     = reg_wr && (reg_addr == ADDR_W'(OFS_BCNT));
    rd_data     = reg_rd && (reg_addr == ADDR_W'(OFS_DATA));
    rx_mode     = mode_q[0];
    tx_mode     = mode_q[1] & ~mode_q[0];
    count_load  = wr_bcnt;
  end

  sdp_rx_packer u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart   (count_load),
    .enable    (rx_mode && (remain_q != '0)),
    .last_byte (remain_q == CNT_W'(1)),
    .fifo_full (fifo_full),
    .rx_valid  (card_rx_valid),
    .rx_data   (card_rx_data),
    .rx_ready  (card_rx_ready),
    .byte_take (rx_take),
    .word_push (rx_push),
    .word_out  (rx_word)
  );

  sdp_tx_unpacker u_tx (
    .clk        (clk),
    .rst_n      (rst_n),
    .restart    (count_load),
    .enable     (tx_mode && (remain_q != '0)),
    .fifo_empty (fifo_empty),
    .fifo_head  (fifo_head),
    .bus_pop    (rd_data),
    .tx_ready   (card_tx_ready),
    .tx_valid   (card_tx_valid),
    .tx_data    (card_tx_data),
    .word_pop   (tx_pop),
    .byte_sent  (tx_sent)
  );

  // packer has priority over a software push in the same cycle
  always_comb begin
    fifo_push  = rx_push | wr_data;
    fifo_wdata = rx_push ? rx_word : reg_wdata;
    fifo_pop   = rd_data | tx_pop;
    byte_evt   = rx_take | tx_sent;
    done_evt   = byte_evt && (remain_q == CNT_W'(1)) && !count_load;
    word_evt   = rx_push | tx_pop;
    blk_evt    = tx_sent && (bsz_q != '0) && (blk_left_q == BSZ_W'(1));
  end

  sdp_word_fifo #(.DEPTH(FIFO_DEPTH), .W(32)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (fifo_push),
    .push_data (fifo_wdata),
    .pop       (fifo_pop),
    .head      (fifo_head),
    .full      (fifo_full),
    .empty     (fifo_empty),
    .level     (fifo_level)
  );

  // transfer length and per-block position
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain_q   <= '0;
      blk_left_q <= '0;
    end else if (count_load) begin
      remain_q   <= CNT_W'(bsz_q) * CNT_W'(reg_wdata[BCNT_W-1:0]);
      blk_left_q <= bsz_q;
    end else begin
      if (byte_evt) remain_q <= remain_q - 1'b1;
      if (tx_sent) blk_left_q <= (blk_left_q <= BSZ_W'(1)) ? bsz_q : blk_left_q - 1'b1;
    end
  end

  // software-visible registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      cfg_q  <= '0;
      bsz_q  <= '0;
      bcnt_q <= '0;
      dbg_q  <= DBG_RESET;
      stat_q <= '0;
    end else begin
      if (wr_mode_sel) mode_q <= reg_wdata[1:0];
      if (wr_cfg)      cfg_q  <= reg_wdata;
      if (wr_bsz)      bsz_q  <= reg_wdata[BSZ_W-1:0];
      if (wr_bcnt)     bcnt_q <= reg_wdata[BCNT_W-1:0];
      if (wr_dbg)      dbg_q  <= dbg_sanitize(reg_wdata);
      if (done_evt)    dbg_q[3:0] <= STATE_DATA;
      // clear by writing ones, then hardware sets win
      stat_q <= (stat_q & ~({3{wr_stat}} &
                 {reg_wdata[ST_BIRQ], reg_wdata[ST_DIRQ], reg_wdata[ST_DATA]}))
              | {blk_evt & cfg_q[CF_BIRQ_EN],
                 word_evt & cfg_q[CF_DIRQ_EN],
                 word_evt};
    end
  end

  always_comb begin
    unique case (reg_addr)
      ADDR_W'(OFS_MODE): reg_rdata = {30'b0, mode_q};
      ADDR_W'(OFS_STAT): reg_rdata = stat_view(stat_q);
      ADDR_W'(OFS_DBG):  reg_rdata = dbg_view(dbg_q, 5'(fifo_level));
      ADDR_W'(OFS_CFG):  reg_rdata = cfg_q;
      ADDR_W'(OFS_BSZ):  reg_rdata = 32'(bsz_q);
      ADDR_W'(OFS_BCNT): reg_rdata = 32'(bcnt_q);
      ADDR_W'(OFS_DATA): reg_rdata = fifo_empty ? 32'h0 : fifo_head;
      default:           reg_rdata = 32'h0;
    endcase
    irq = stat_q[1] | stat_q[2];
  end

  // R3: every moved byte lowers the count by exactly one
  a_r3_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_evt && !count_load) |=> (remain_q == $past(remain_q) - 1'b1));

  // R6: the packer never takes a byte while the FIFO is full
  a_r6_no_take_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    rx_take |-> !fifo_full);

  // R7: no byte is offered to the card once the count is used up
  a_r7_tx_needs_count: assert property (@(posedge clk) disable iff (!rst_n)
    card_tx_valid |-> (remain_q != '0));

  // R8: a card-side word movement raises the data flag
  a_r8_flag_follows_word: assert property (@(posedge clk) disable iff (!rst_n)
    word_evt |=> stat_q[0]);

  // R10: the final byte moves the debug state to data mode
  a_r10_done_state: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> (dbg_q[3:0] == STATE_DATA && remain_q == '0));

  // R2: an empty data read returns zero
  a_r2_empty_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data && fifo_empty) |-> (reg_rdata == 32'h0));

endmodule

// File: tb/tb_sd_fifo_packer.sv
module tb_sd_fifo_packer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        card_rx_valid = 1'b0;
  logic [7:0]  card_rx_data = '0;
  logic        card_rx_ready;
  logic        card_tx_valid;
  logic [7:0]  card_tx_data;
  logic        card_tx_ready = 1'b0;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #10 clk = ~clk;

  sd_fifo_packer dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .card_rx_valid(card_rx_valid), .card_rx_data(card_rx_data),
    .card_rx_ready(card_rx_ready), .card_tx_valid(card_tx_valid),
    .card_tx_data(card_tx_data), .card_tx_ready(card_tx_ready), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  // all tasks start and end just after a falling edge
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic card_put(input logic [7:0] b);
    card_rx_valid = 1'b1; card_rx_data = b;
    #1;
    while (!card_rx_ready) @(negedge clk);
    @(negedge clk);
    card_rx_valid = 1'b0;
  endtask

  task automatic card_get(output logic [7:0] b);
    card_tx_ready = 1'b1;
    #1;
    while (!card_tx_valid) begin @(negedge clk); #1; end
    b = card_tx_data;
    @(negedge clk);
    card_tx_ready = 1'b0;
  endtask

  function automatic logic [4:0] lvl_of(input logic [31:0] dbg);
    return dbg[8:4];
  endfunction

  task automatic t_reset;
    logic [31:0] v;
    rd(8'h34, v); chk("R11 debug reset value", v, 32'h0000_C60F);
    rd(8'h20, v); chk("R12 status reset", v, 32'h0);
    chk("R12 irq reset", 32'(irq), 32'h0);
    chk("R6 rx_ready low at reset", 32'(card_rx_ready), 32'h0);
    chk("R7 tx_valid low at reset", 32'(card_tx_valid), 32'h0);
  endtask

  task automatic t_fifo_limits;
    logic [31:0] v;
    for (int i = 0; i < 17; i++) wr(8'h40, 32'h1000_0000 + 32'(i));
    rd(8'h34, v); chk("R1 level at full", 32'(lvl_of(v)), 32'd16);
    for (int i = 0; i < 16; i++) begin
      rd(8'h40, v); chk("R1 fifo order, overflow push dropped", v, 32'h1000_0000 + 32'(i));
    end
    rd(8'h40, v); chk("R2 empty pop returns zero", v, 32'h0);
    rd(8'h34, v); chk("R2 level stays zero", 32'(lvl_of(v)), 32'd0);
  endtask

  task automatic t_rx_pack;
    logic [31:0] v;
    wr(8'h00, 32'h1);
    wr(8'h38, 32'h10);
    wr(8'h3C, 32'd6);
    wr(8'h50, 32'd1);
    for (int i = 0; i < 6; i++) card_put(8'h11 + 8'(i));
    #1 chk("R6 rx_ready low when count zero", 32'(card_rx_ready), 32'h0);
    rd(8'h40, v); chk("R4 lanes little endian", v, {8'h14, 8'h13, 8'h12, 8'h11});
    rd(8'h40, v); chk("R5 partial word zero filled", v, {16'h0, 8'h16, 8'h15});
    rd(8'h20, v); chk("R8 data flag and data irq", v, 32'h0000_0101);
    chk("R12 irq from data irq", 32'(irq), 32'h1);
    rd(8'h34, v); chk("R10 state data mode", {28'h0, v[3:0]}, 32'h1);
    wr(8'h20, 32'h101);
    rd(8'h20, v); chk("R12 write one clears", v, 32'h0);
    chk("R12 irq drops", 32'(irq), 32'h0);
  endtask

  task automatic t_rx_stall;
    logic [31:0] v;
    wr(8'h3C, 32'd4);
    wr(8'h50, 32'd17);
    for (int i = 0; i < 64; i++) card_put(8'(i));
    card_rx_valid = 1'b1; card_rx_data = 8'd64;
    #1 chk("R6 rx_ready low when full", 32'(card_rx_ready), 32'h0);
    card_rx_valid = 1'b0;
    rd(8'h34, v); chk("R1 level 16 after stall", 32'(lvl_of(v)), 32'd16);
    rd(8'h40, v); chk("R4 first stalled word", v, 32'h0302_0100);
    #1 chk("R6 rx_ready returns after pop", 32'(card_rx_ready), 32'h1);
    for (int i = 64; i < 68; i++) card_put(8'(i));
    for (int k = 1; k < 17; k++) begin
      logic [7:0] b0;
      b0 = 8'(4 * k);
      rd(8'h40, v);
      chk("R4 drained word after resume", v, {b0 + 8'd3, b0 + 8'd2, b0 + 8'd1, b0});
    end
    wr(8'h20, 32'hFFFF_FFFF);
  endtask

  task automatic t_tx_unpack;
    logic [31:0] v;
    logic [7:0]  b;
    logic [7:0]  exp_b [6];
    exp_b = '{8'hA1, 8'hA2, 8'hA3, 8'hA4, 8'hB1, 8'hB2};
    wr(8'h00, 32'h2);
    wr(8'h38, 32'h110);
    wr(8'h40, 32'hA4A3_A2A1);
    wr(8'h40, 32'hB4B3_B2B1);
    wr(8'h3C, 32'd3);
    wr(8'h50, 32'd2);
    for (int i = 0; i < 3; i++) begin
      card_get(b); chk("R7 byte order lsb first", 32'(b), 32'(exp_b[i]));
    end
    rd(8'h20, v); chk("R9 block irq after first block", v, 32'h0000_0301);
    wr(8'h20, 32'h301);
    for (int i = 3; i < 6; i++) begin
      card_get(b); chk("R7 byte order second word", 32'(b), 32'(exp_b[i]));
    end
    #1 chk("R7 tx_valid low after count zero", 32'(card_tx_valid), 32'h0);
    rd(8'h20, v); chk("R9 block irq after second block", v, 32'h0000_0301);
    rd(8'h34, v); chk("R10 state data mode after write", {28'h0, v[3:0]}, 32'h1);
    chk("R1 level zero after write", 32'(lvl_of(v)), 32'd0);
    wr(8'h20, 32'hFFFF_FFFF);
  endtask

  task automatic t_tx_no_irq;
    logic [31:0] v;
    logic [7:0]  b;
    wr(8'h38, 32'h0);
    wr(8'h40, 32'hCAFE_BABE);
    wr(8'h3C, 32'd2);
    wr(8'h50, 32'd1);
    card_get(b); chk("R7 first byte", 32'(b), 32'hBE);
    card_get(b); chk("R7 second byte", 32'(b), 32'hBA);
    rd(8'h20, v); chk("R8 R9 enables off give only data flag", v, 32'h1);
    chk("R12 irq stays low", 32'(irq), 32'h0);
    wr(8'h20, 32'h1);
  endtask

  task automatic t_debug_and_mode;
    logic [31:0] v;
    wr(8'h34, 32'h0000_ABCF);
    rd(8'h34, v); chk("R11 power-down code stored as zero", v, 32'h0000_AA00);
    wr(8'h34, 32'h5);
    rd(8'h34, v); chk("R11 plain state write", v, 32'h5);
    wr(8'h00, 32'h0);
    wr(8'h3C, 32'd4);
    wr(8'h50, 32'd1);
    wr(8'h40, 32'h1234_5678);
    #1 chk("R13 idle mode no rx", 32'(card_rx_ready), 32'h0);
    chk("R13 idle mode no tx", 32'(card_tx_valid), 32'h0);
    rd(8'h34, v); chk("R13 word held in idle", 32'(lvl_of(v)), 32'd1);
    rd(8'h40, v); chk("R13 held word intact", v, 32'h1234_5678);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fifo_limits();
    t_rx_pack();
    t_rx_stall();
    t_tx_unpack();
    t_tx_no_irq();
    t_debug_and_mode();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=<20000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule